// File: doc/BRIEF.md
# FIFO DMA Interrupt Status Register

This block collects the interrupt events of a FIFO-fed DMA client that has one transmit and one receive channel. Each channel sees event pulses from the DMA master, from the bus slave port and from an attached IO device. It also sees the fill level of its FIFO, from which the block derives four conditions of its own: nearly full, empty, free space above a programmed threshold, and data left sitting too long. A fifth derived condition flags an IO request the DMA cannot serve. Every event is caught on the rising edge of its condition and held in a sticky status bit until software clears it.

Software reaches the block through a small word-wide register port. It has four addresses: the status word, an interrupt enable mask, the two free-space thresholds, and the stall-timeout limit. A single interrupt line is raised whenever any enabled status bit is set.

Top module: `fifo_dma_irq_status`

## Requirements
- R1: After reset every status bit reads 0, the enable mask reads 0 and the interrupt output is low. The status word is at address 0, with transmit events in bits 0..8 and receive events in bits 16..24. Within each group the bit order is IO interrupt 0, master error 1, slave error 2, done 3, unserved IO request 4, stall timeout 5, free-space threshold 6, full 7, empty 8.
- R2: A write to address 0 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. If a bit's condition rises in the same cycle as a clear of that bit, the bit ends set.
- R3: A status bit is set at the clock edge where its condition is first sampled true, and it is visible right after that edge. A condition that stays true does not set the bit again once it has been cleared.
- R4: Each direction's IO interrupt bit is set when that direction's IO device raises its request input.
- R5: A master error sets the transmit master-error bit when the arbiter grant input is 0, and the receive master-error bit when the grant input is 1.
- R6: A slave-error pulse sets that direction's slave-error bit, and a transfer-done pulse sets that direction's done bit.
- R7: The full bit is set when free bytes (DEPTH minus level) drop below 4; exactly 4 free bytes is not full. The empty bit is set when the level becomes 0.
- R8: The threshold bit is set when free bytes become strictly greater than that direction's threshold. The thresholds are held at address 2, transmit in bits [15:0] and receive in bits [31:16], each with DEPTH/2 as the reset value.
- R9: A per-direction stall counter reloads to 0 on every pop and whenever the FIFO is empty, and otherwise counts up to the limit held at address 3. The stall bit is set on the edge after the counter reaches the limit, so it fires once per stall episode. A limit of 0 disables it.
- R10: The unserved-IO-request bit is set when DMA is active and an IO request is pending while the FIFO is empty or no DMA cycle is in progress.
- R11: The interrupt output is high exactly when some status bit is set and its bit at the same position in the mask (address 1) is 1.
- R12: The mask, threshold and limit registers read back what was last written, masked to their field widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (read and write) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational on regAddr |
| irq | output | 1 | Combined masked interrupt |
| fifoLevelTx | input | LVL_W | Transmit FIFO fill level in bytes |
| fifoLevelRx | input | LVL_W | Receive FIFO fill level in bytes |
| fifoPop | input | 2 | FIFO drain strobe per direction (bit 0 transmit) |
| dmaActive | input | 2 | DMA enabled per direction |
| dmaCycleOn | input | 2 | A DMA cycle is in progress per direction |
| ioReqPend | input | 2 | IO device requests service per direction |
| ioIrqReq | input | 2 | IO device interrupt request per direction |
| busMstErr | input | 1 | Bus master received an error response |
| arbGrantRx | input | 1 | Arbiter grants the receive FIFO (0 grants transmit) |
| slvErr | input | 2 | Bus slave drove an error per direction |
| dmaDone | input | 2 | Master-mode transfer completed per direction |

## Verification
A wrong edge-detect register either drops an event or repeats one after software clears it. Either fault shows in the status word one cycle after the condition changes. A stall counter that reloads at the wrong time moves the timeout bit by at least one cycle, or makes it fire twice in one episode. A mask or clear fault shows on the interrupt line in the cycle right after the register write. The reference model runs every cycle, so each of these faults is caught within one clock of its first visible effect.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int NUM_DIR    = 2;
  localparam int DIR_STRIDE = 16;
  localparam int EV_COUNT   = 9;

  // bit positions inside one direction group
  localparam int B_IO    = 0;
  localparam int B_MERR  = 1;
  localparam int B_SERR  = 2;
  localparam int B_DONE  = 3;
  localparam int B_IOREQ = 4;
  localparam int B_STALL = 5;
  localparam int B_ENTRY = 6;
  localparam int B_FULL  = 7;
  localparam int B_EMPTY = 8;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_THRESH = 2'd2,
    A_LIMIT  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic        clrStatus;
    logic        wrMask;
    logic        wrThresh;
    logic        wrLimit;
    logic [31:0] data;
  } regStrobe_t;
endpackage

// File: rtl/isr_fifo_cond.sv
module isr_fifo_cond #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] level,
  input  logic             pop,
  input  logic             dmaActive,
  input  logic             cycleOn,
  input  logic             ioReq,
  input  logic [LVL_W-1:0] thresh,
  input  logic [TO_W-1:0]  limit,
  output logic             fullCond,
  output logic             emptyCond,
  output logic             entryCond,
  output logic             stallCond,
  output logic             ioreqCond
);
  localparam int FW = LVL_W + 1;
  localparam logic [FW-1:0] DEPTH_V = FW'(DEPTH);
  localparam logic [FW-1:0] FULL_MARGIN = FW'(4);

  logic [FW-1:0]   freeBytes;
  logic [TO_W-1:0] stallCnt;

  assign freeBytes = DEPTH_V - {1'b0, level};
  assign fullCond  = freeBytes < FULL_MARGIN;
  assign emptyCond = (level == '0);
  assign entryCond = freeBytes > {1'b0, thresh};
  assign ioreqCond = dmaActive && ioReq && (emptyCond || !cycleOn);
  assign stallCond = (limit != '0) && (stallCnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   stallCnt <= '0;
    else if (pop || emptyCond)   stallCnt <= '0;
    else if (stallCnt != limit)  stallCnt <= stallCnt + 1'b1;
  end

  // R9: a drain or an empty FIFO restarts the stall window
  a_r9_reload: assert property (@(posedge clk) disable iff (!rstN)
    (pop || emptyCond) |=> (stallCnt == '0));
endmodule

// File: rtl/isr_reg_ctrl.sv
module isr_reg_ctrl
  import isr_pkg::*;
(
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output regStrobe_t  strb
);
  regAddr_e addrE;
  assign addrE = regAddr_e'(regAddr);

  always_comb begin
    strb           = '0;
    strb.data      = regWdata;
    if (regWrEn) begin
      unique case (addrE)
        A_STATUS: strb.clrStatus = 1'b1;
        A_MASK:   strb.wrMask    = 1'b1;
        A_THRESH: strb.wrThresh  = 1'b1;
        A_LIMIT:  strb.wrLimit   = 1'b1;
        default:  strb.clrStatus = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/isr_status_dp.sv
module isr_status_dp
  import isr_pkg::*;
#(
  parameter int LVL_W   = 7,
  parameter int TO_W    = 16,
  parameter int THR_RST = 32,
  parameter int LIM_RST = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [1:0]       rdAddr,
  input  logic [31:0]      condVec,
  output logic [31:0]      rdata,
  output logic             irq,
  output logic [LVL_W-1:0] threshTx,
  output logic [LVL_W-1:0] threshRx,
  output logic [TO_W-1:0]  limit
);
  logic [31:0] statusQ;
  logic [31:0] maskQ;
  logic [31:0] prevCond;
  logic [31:0] setVec;
  logic [31:0] clrVec;

  assign setVec = condVec & ~prevCond;
  assign clrVec = strb.clrStatus ? strb.data : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCond <= '1;
      statusQ  <= '0;
    end else begin
      prevCond <= condVec;
      statusQ  <= (statusQ & ~clrVec) | setVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      threshTx <= LVL_W'(THR_RST);
      threshRx <= LVL_W'(THR_RST);
      limit    <= TO_W'(LIM_RST);
    end else begin
      if (strb.wrMask)   maskQ <= strb.data;
      if (strb.wrThresh) begin
        threshTx <= strb.data[LVL_W-1:0];
        threshRx <= strb.data[DIR_STRIDE +: LVL_W];
      end
      if (strb.wrLimit)  limit <= strb.data[TO_W-1:0];
    end
  end

  always_comb begin
    unique case (regAddr_e'(rdAddr))
      A_STATUS: rdata = statusQ;
      A_MASK:   rdata = maskQ;
      A_THRESH: rdata = (32'(threshRx) << DIR_STRIDE) | 32'(threshTx);
      default:  rdata = 32'(limit);
    endcase
  end

  assign irq = |(statusQ & maskQ);

  // R2: a write-one clear without a competing set leaves the bit at 0
  a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrVec & ~setVec)) |=> ((statusQ & $past(clrVec & ~setVec)) == '0));
  // R3: a rising condition is always captured, clear or not
  a_r3_set: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((statusQ & $past(setVec)) == $past(setVec)));
  // R3: no status bit appears without a rising condition
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(setVec)) == '0));
endmodule

// File: rtl/fifo_dma_irq_status.sv
module fifo_dma_irq_status
  import isr_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LVL_W   = $clog2(DEPTH + 1),
  parameter int TO_W    = 16,
  parameter int LIM_RST = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             irq,
  input  logic [LVL_W-1:0] fifoLevelTx,
  input  logic [LVL_W-1:0] fifoLevelRx,
  input  logic [1:0]       fifoPop,
  input  logic [1:0]       dmaActive,
  input  logic [1:0]       dmaCycleOn,
  input  logic [1:0]       ioReqPend,
  input  logic [1:0]       ioIrqReq,
  input  logic             busMstErr,
  input  logic             arbGrantRx,
  input  logic [1:0]       slvErr,
  input  logic [1:0]       dmaDone
);
  localparam int THR_RST = DEPTH / 2;

  regStrobe_t                  strb;
  logic [31:0]                 condVec;
  logic [NUM_DIR-1:0][LVL_W-1:0] levelArr;
  logic [NUM_DIR-1:0][LVL_W-1:0] threshArr;
  logic [LVL_W-1:0]            threshTx;
  logic [LVL_W-1:0]            threshRx;
  logic [TO_W-1:0]             limit;

  assign levelArr  = {fifoLevelRx, fifoLevelTx};
  assign threshArr = {threshRx, threshTx};

  isr_reg_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .strb    (strb)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam int BASE = d * DIR_STRIDE;
    logic granted;
    assign granted = (d == 1) ? arbGrantRx : !arbGrantRx;

    isr_fifo_cond #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TO_W(TO_W)) u_cond (
      .clk      (clk),
      .rstN     (rstN),
      .level    (levelArr[d]),
      .pop      (fifoPop[d]),
      .dmaActive(dmaActive[d]),
      .cycleOn  (dmaCycleOn[d]),
      .ioReq    (ioReqPend[d]),
      .thresh   (threshArr[d]),
      .limit    (limit),
      .fullCond (condVec[BASE + B_FULL]),
      .emptyCond(condVec[BASE + B_EMPTY]),
      .entryCond(condVec[BASE + B_ENTRY]),
      .stallCond(condVec[BASE + B_STALL]),
      .ioreqCond(condVec[BASE + B_IOREQ])
    );

    assign condVec[BASE + B_IO]   = ioIrqReq[d];
    assign condVec[BASE + B_MERR] = busMstErr && granted;
    assign condVec[BASE + B_SERR] = slvErr[d];
    assign condVec[BASE + B_DONE] = dmaDone[d];
    assign condVec[BASE + EV_COUNT +: (DIR_STRIDE - EV_COUNT)] = '0;
  end

  isr_status_dp #(
    .LVL_W  (LVL_W),
    .TO_W   (TO_W),
    .THR_RST(THR_RST),
    .LIM_RST(LIM_RST)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdAddr  (regAddr),
    .condVec (condVec),
    .rdata   (regRdata),
    .irq     (irq),
    .threshTx(threshTx),
    .threshRx(threshRx),
    .limit   (limit)
  );
endmodule

// File: tb/fifo_dma_irq_status_tb.sv
module fifo_dma_irq_status_tb;
  localparam int DEPTH = 64;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int TO_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irq;
  logic [LVL_W-1:0] fifoLevelTx = '0, fifoLevelRx = '0;
  logic [1:0] fifoPop = '0, dmaActive = '0, dmaCycleOn = '0, ioReqPend = '0;
  logic [1:0] ioIrqReq = '0, slvErr = '0, dmaDone = '0;
  logic busMstErr = 1'b0, arbGrantRx = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  fifo_dma_irq_status #(.DEPTH(DEPTH), .TO_W(TO_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .fifoLevelTx(fifoLevelTx), .fifoLevelRx(fifoLevelRx), .fifoPop(fifoPop),
    .dmaActive(dmaActive), .dmaCycleOn(dmaCycleOn), .ioReqPend(ioReqPend),
    .ioIrqReq(ioIrqReq), .busMstErr(busMstErr), .arbGrantRx(arbGrantRx),
    .slvErr(slvErr), .dmaDone(dmaDone)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] mStatus, mMask, setv, clr;
  int mThr[2];
  int mLim;
  int mCnt[2];
  logic [8:0] mPrev[2];
  logic [8:0] c;
  int lvl, freeB;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStatus = '0; mMask = '0; mLim = 0;
      for (int d = 0; d < 2; d++) begin
        mThr[d] = DEPTH / 2; mCnt[d] = 0; mPrev[d] = '1;
      end
    end else begin
      cycles++;
      setv = '0; clr = '0;
      for (int d = 0; d < 2; d++) begin
        lvl   = (d == 1) ? int'(fifoLevelRx) : int'(fifoLevelTx);
        freeB = DEPTH - lvl;
        c[0] = ioIrqReq[d];
        c[1] = busMstErr && (int'(arbGrantRx) == d);
        c[2] = slvErr[d];
        c[3] = dmaDone[d];
        c[4] = dmaActive[d] && ioReqPend[d] && (lvl == 0 || !dmaCycleOn[d]);
        c[5] = (mLim != 0) && (mCnt[d] == mLim);
        c[6] = freeB > mThr[d];
        c[7] = freeB < 4;
        c[8] = (lvl == 0);
        for (int b = 0; b < 9; b++) begin
          if (c[b] && !mPrev[d][b]) setv[d*16 + b] = 1'b1;
        end
        mPrev[d] = c;
        if (fifoPop[d] || lvl == 0) mCnt[d] = 0;
        else if (mCnt[d] != mLim) mCnt[d] = mCnt[d] + 1;
      end
      if (regWrEn) begin
        case (regAddr)
          2'd0: clr = regWdata;
          2'd1: mMask = regWdata;
          2'd2: begin
            mThr[0] = int'(regWdata[LVL_W-1:0]);
            mThr[1] = int'(regWdata[16 +: LVL_W]);
          end
          default: mLim = int'(regWdata[TO_W-1:0]);
        endcase
      end
      mStatus = (mStatus & ~clr) | setv;
    end
  end

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mStatus;
      2'd1: return mMask;
      2'd2: return (32'(mThr[1]) << 16) | 32'(mThr[0]);
      default: return 32'(mLim);
    endcase
  endfunction

  function automatic string reqOfBit(input int b);
    case (b % 16)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R10";
      5: return "R9";
      6: return "R8";
      7, 8: return "R7";
      default: return "R1";
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      logic [31:0] e;
      e = expRead(regAddr);
      checks++;
      if (regRdata !== e) begin
        string rq;
        rq = "R12";
        if (regAddr == 2'd0) begin
          for (int b = 31; b >= 0; b--) if (regRdata[b] !== e[b]) rq = reqOfBit(b);
        end
        errors++;
        $display("FAIL %s: addr %0d read %h expected %h at cycle %0d", rq, regAddr, regRdata, e, cycles);
      end
      checks++;
      if (irq !== (|(mStatus & mMask))) begin
        errors++;
        $display("FAIL R11: irq %b expected %b at cycle %0d", irq, |(mStatus & mMask), cycles);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] dat);
    regWrEn = 1'b1; regAddr = a; regWdata = dat;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0; regWdata = '0;
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [31:0] exp, input string rq);
    regAddr = a;
    #1;
    check(regRdata, exp, rq);
    regAddr = 2'd0;
  endtask

  task automatic expectBits(input logic [31:0] m, input logic [31:0] exp, input string rq);
    check(regRdata & m, exp, rq);
  endtask

  // watchdog
  always @(negedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1: reset state
    check(regRdata, 32'h0, "R1");
    check({31'b0, irq}, 32'h0, "R1");
    readCheck(2'd1, 32'h0, "R1");

    // R12: configuration readback
    regWrite(2'd2, 32'h0014_000A);
    regWrite(2'd3, 32'h0000_0005);
    readCheck(2'd2, 32'h0014_000A, "R12");
    readCheck(2'd3, 32'h0000_0005, "R12");

    // R4: IO interrupt per direction
    ioIrqReq = 2'b01; step(1); ioIrqReq = 2'b00;
    expectBits(32'h0000_0001, 32'h0000_0001, "R4");
    ioIrqReq = 2'b10; step(1); ioIrqReq = 2'b00;
    expectBits(32'h0001_0000, 32'h0001_0000, "R4");

    // R2: write one clears, write zero keeps
    regWrite(2'd0, 32'h0000_0001);
    expectBits(32'h0001_0001, 32'h0001_0000, "R2");

    // R5: master error follows the grant
    busMstErr = 1'b1; arbGrantRx = 1'b1; step(1); busMstErr = 1'b0;
    expectBits(32'h0002_0002, 32'h0002_0000, "R5");
    busMstErr = 1'b1; arbGrantRx = 1'b0; step(1); busMstErr = 1'b0;
    expectBits(32'h0000_0002, 32'h0000_0002, "R5");

    // R6: slave error and done
    slvErr = 2'b01; dmaDone = 2'b10; step(1); slvErr = '0; dmaDone = '0;
    expectBits(32'h0008_0004, 32'h0008_0004, "R6");

    // R7: full boundary and empty
    regWrite(2'd0, 32'hFFFF_FFFF);
    fifoLevelTx = 7'd60; step(1);
    expectBits(32'h0000_0080, 32'h0, "R7");
    fifoLevelTx = 7'd61; step(1);
    expectBits(32'h0000_0080, 32'h0000_0080, "R7");
    fifoLevelTx = 7'd0; step(1);
    expectBits(32'h0000_0100, 32'h0000_0100, "R7");

    // R8: threshold strictly greater (tx threshold 10)
    fifoLevelTx = 7'd60; step(1);
    regWrite(2'd0, 32'hFFFF_FFFF);
    fifoLevelTx = 7'd54; step(1);
    expectBits(32'h0000_0040, 32'h0, "R8");
    fifoLevelTx = 7'd53; step(1);
    expectBits(32'h0000_0040, 32'h0000_0040, "R8");

    // R9: stall timeout with limit 5
    fifoLevelTx = 7'd8;
    fifoPop = 2'b01; step(1); fifoPop = 2'b00;
    regWrite(2'd0, 32'hFFFF_FFFF);
    step(3);
    expectBits(32'h0000_0020, 32'h0, "R9");
    step(2);
    expectBits(32'h0000_0020, 32'h0000_0020, "R9");
    regWrite(2'd0, 32'h0000_0020);
    step(5);
    expectBits(32'h0000_0020, 32'h0, "R9");
    fifoPop = 2'b01; step(1); fifoPop = 2'b00;
    step(6);
    expectBits(32'h0000_0020, 32'h0000_0020, "R9");

    // R10: unserved IO request
    fifoLevelTx = 7'd0; step(1);
    regWrite(2'd0, 32'hFFFF_FFFF);
    dmaActive = 2'b01; ioReqPend = 2'b01; dmaCycleOn = 2'b01; step(1);
    expectBits(32'h0000_0010, 32'h0000_0010, "R10");
    fifoLevelRx = 7'd30; step(1);
    dmaActive = 2'b11; ioReqPend = 2'b11; dmaCycleOn = 2'b11; step(1);
    expectBits(32'h0010_0000, 32'h0, "R10");
    dmaCycleOn = 2'b01; step(1);
    expectBits(32'h0010_0000, 32'h0010_0000, "R10");
    dmaActive = '0; ioReqPend = '0; dmaCycleOn = '0;

    // R3: held condition does not re-set after clear
    ioIrqReq = 2'b01; step(1);
    regWrite(2'd0, 32'h0000_0001);
    step(2);
    expectBits(32'h0000_0001, 32'h0, "R3");
    ioIrqReq = 2'b00; step(1);

    // R2: set wins over same-cycle clear
    ioIrqReq = 2'b01;
    regWrite(2'd0, 32'h0000_0001);
    ioIrqReq = 2'b00;
    expectBits(32'h0000_0001, 32'h0000_0001, "R2");

    // R11: masked interrupt
    check({31'b0, irq}, 32'h0, "R11");
    regWrite(2'd1, 32'h0000_0001);
    check({31'b0, irq}, 32'h1, "R11");
    regWrite(2'd0, 32'h0000_0001);
    check({31'b0, irq}, 32'h0, "R11");
    readCheck(2'd1, 32'h0000_0001, "R12");

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule